// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that completes one instruction on every rising clock edge. It holds a program counter, a constant instruction store, a 32-entry register file, an arithmetic unit, a two-step instruction decoder and a word-organised data memory. The instruction store holds a fixed built-in program. That program loads three words, combines them with register arithmetic and runs a short counting loop. It then builds the constant 0x20000014 and stores a word to that address, loads it back, and returns to address 0 through a register jump. After that it repeats forever.

The decoder works in two steps. First it sorts the opcode into an instruction class: CLS_RTYPE, CLS_JUMP, CLS_BEQ, CLS_ADDI, CLS_ORI, CLS_LUI, CLS_LOAD, CLS_STORE or CLS_NOP. Then, for each class, it produces the datapath controls. The register-type class looks at the function code and picks the operation (ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT) or a register jump. The program counter has three kinds of transition: sequential (PC+4), taken or not-taken compare-branch, and jump (absolute or through a register). The program counter and any register, through an observation port, can be read at the block's ports.

Top module: `scpu_core`

## Requirements
- R1: While the active-low reset is asserted, the program counter is 0 and every register reads 0. The data memory is reloaded to its power-up contents (R10).
- R2: Any instruction that is not a branch or jump advances the program counter by exactly 4 at the next clock edge.
- R3: beq (opcode 0x04) compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended 16-bit offset times 4; otherwise it is PC+4. An offset of 0xFFFD at address 0x2C gives 0x24.
- R4: j (opcode 0x02) loads the PC with bits 31..28 of PC+4, followed by the 26-bit index and two zero bits. Index 0x0A gives 0x28.
- R5: The register jump (register-type, function 0x08) loads the PC with the value of rs and writes no register.
- R6: Register 0 always reads as zero, on every read port including the observation port, and writes aimed at it are dropped.
- R7: Register-type function codes 0x20, 0x22, 0x24, 0x25 and 0x2A write rs+rt, rs−rt, rs AND rt, rs OR rt, and the signed rs<rt test (1 or 0) into rd.
- R8: addi (0x08) adds a sign-extended immediate. ori (0x0D) ORs a zero-extended immediate. lui (0x0F) writes the immediate to bits 31..16 and zeroes bits 15..0.
- R9: lw (0x23) and sw (0x2B) use the byte address rs plus the sign-extended offset. Only byte-address bits 7..2 select the word, so 0x20000014 reaches word 5, and a load returns what was last stored there.
- R10: The data memory starts with 3, 4, 5 and 6 in words 0 to 3 and zero in every other word.
- R11: One pass of the built-in program takes 22 cycles. The PC is then back at 0 with r1=3, r2=4, r3=7, r4=7, r5=1, r6=0, r7=1, r8=2, r9=0x20000014, r10=2 and all other registers 0. Every later pass ends in the same state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction completes per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 32 | Current program counter (byte address) |
| obs_sel | input | 5 | Register number shown on obs_data |
| obs_data | output | 32 | Combinational value of the selected register |

## Verification
Every instruction retires in the cycle it is fetched. A wrong next-PC choice therefore shows on pc_o at the very next edge, and the bench compares pc_o against the expected address trace after every edge. A wrong operation, extension or memory word shows up in the observed registers within a few cycles, at points inside the pass where the bench reads them. Those points are after the loads, after the register arithmetic, after each loop step and after the constant build. A store-to-load fault stays hidden until the final load, so the register sweep at the end of each pass, done in a shuffled order, catches it. A reset at a random point inside a pass checks that the core restarts cleanly.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RA_W      = $clog2(REG_COUNT);
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int IMM_W     = 16;
    localparam int IDX_W     = 26;

    // opcodes
    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OPC_J       = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ     = 6'h04;
    localparam logic [OP_W-1:0] OPC_ADDI    = 6'h08;
    localparam logic [OP_W-1:0] OPC_ORI     = 6'h0D;
    localparam logic [OP_W-1:0] OPC_LUI     = 6'h0F;
    localparam logic [OP_W-1:0] OPC_LW      = 6'h23;
    localparam logic [OP_W-1:0] OPC_SW      = 6'h2B;

    // register-type function codes
    localparam logic [FN_W-1:0] FN_JR  = 6'h08;
    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        CLS_NOP,
        CLS_RTYPE,
        CLS_JUMP,
        CLS_BEQ,
        CLS_ADDI,
        CLS_ORI,
        CLS_LUI,
        CLS_LOAD,
        CLS_STORE
    } instr_class_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_LUI
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    src_imm;
        logic    imm_zext;
        logic    mem_to_reg;
        logic    mem_write;
        logic    branch_eq;
        logic    jump;
        logic    jump_reg;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] enc_r(input logic [RA_W-1:0] rs,
                                              input logic [RA_W-1:0] rt,
                                              input logic [RA_W-1:0] rd,
                                              input logic [FN_W-1:0] fn);
        return {OPC_SPECIAL, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [XLEN-1:0] enc_i(input logic [OP_W-1:0]  op,
                                              input logic [RA_W-1:0]  rs,
                                              input logic [RA_W-1:0]  rt,
                                              input logic [IMM_W-1:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [XLEN-1:0] enc_j(input logic [OP_W-1:0]  op,
                                              input logic [IDX_W-1:0] idx);
        return {op, idx};
    endfunction

    // Built-in program, one word per slot; unused slots decode as no-ops.
    function automatic logic [XLEN-1:0] prog_word(input int unsigned slot);
        logic [XLEN-1:0] w;
        unique case (slot)
            0:       w = enc_r(5'd0, 5'd0, 5'd8, FN_ADD);
            1:       w = enc_i(OPC_LW, 5'd0, 5'd1, 16'h0000);
            2:       w = enc_i(OPC_LW, 5'd0, 5'd2, 16'h0004);
            3:       w = enc_i(OPC_LW, 5'd0, 5'd3, 16'h0008);
            4:       w = enc_r(5'd2, 5'd1, 5'd3, FN_ADD);
            5:       w = enc_r(5'd2, 5'd1, 5'd4, FN_OR);
            6:       w = enc_r(5'd2, 5'd1, 5'd5, FN_SUB);
            7:       w = enc_r(5'd2, 5'd1, 5'd6, FN_AND);
            8:       w = enc_j(OPC_J, 26'h000000A);
            9:       w = enc_i(OPC_ADDI, 5'd8, 5'd8, 16'h0001);
            10:      w = enc_r(5'd0, 5'd8, 5'd7, FN_SLT);
            11:      w = enc_i(OPC_BEQ, 5'd7, 5'd8, 16'hFFFD);
            12:      w = enc_i(OPC_LUI, 5'd0, 5'd9, 16'h2000);
            13:      w = enc_i(OPC_ORI, 5'd9, 5'd9, 16'h0014);
            14:      w = enc_i(OPC_SW, 5'd9, 5'd8, 16'h0000);
            15:      w = enc_i(OPC_LW, 5'd9, 5'd10, 16'h0000);
            16:      w = enc_r(5'd0, 5'd0, 5'd0, FN_JR);
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/scpu_decoder.sv
module scpu_decoder
    import scpu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output instr_class_e    cls,
    output ctrl_t           ctrl
);

    // Step 1: opcode -> instruction class
    always_comb begin
        unique case (opcode)
            OPC_SPECIAL: cls = CLS_RTYPE;
            OPC_J:       cls = CLS_JUMP;
            OPC_BEQ:     cls = CLS_BEQ;
            OPC_ADDI:    cls = CLS_ADDI;
            OPC_ORI:     cls = CLS_ORI;
            OPC_LUI:     cls = CLS_LUI;
            OPC_LW:      cls = CLS_LOAD;
            OPC_SW:      cls = CLS_STORE;
            default:     cls = CLS_NOP;
        endcase
    end

    // Step 2: class (and function code) -> datapath controls
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (cls)
            CLS_RTYPE: begin
                unique case (funct)
                    FN_ADD: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_AND; end
                    FN_OR:  begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
                    FN_SLT: begin ctrl.reg_write = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
                    FN_JR:  ctrl.jump_reg = 1'b1;
                    default: ;
                endcase
            end
            CLS_JUMP: ctrl.jump = 1'b1;
            CLS_BEQ: begin
                ctrl.branch_eq = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            CLS_ADDI: begin
                ctrl.reg_write = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            CLS_ORI: begin
                ctrl.reg_write = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.imm_zext  = 1'b1;
                ctrl.alu_op    = ALU_OR;
            end
            CLS_LUI: begin
                ctrl.reg_write = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.imm_zext  = 1'b1;
                ctrl.alu_op    = ALU_LUI;
            end
            CLS_LOAD: begin
                ctrl.reg_write  = 1'b1;
                ctrl.src_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.alu_op     = ALU_ADD;
            end
            CLS_STORE: begin
                ctrl.mem_write = 1'b1;
                ctrl.src_imm   = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    localparam int HALF = W / 2;

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
    import scpu_pkg::*;
#(
    parameter int NREG = REG_COUNT,
    parameter int W    = XLEN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra_addr,
    output logic [W-1:0]            ra_data,
    input  logic [$clog2(NREG)-1:0] rb_addr,
    output logic [W-1:0]            rb_data,
    input  logic [$clog2(NREG)-1:0] ro_addr,
    output logic [W-1:0]            ro_data,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd
);

    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != AW'(0))) begin
            regs[wa] <= wd;
        end
    end

    assign ra_data = (ra_addr == AW'(0)) ? '0 : regs[ra_addr];
    assign rb_data = (rb_addr == AW'(0)) ? '0 : regs[rb_addr];
    assign ro_data = (ro_addr == AW'(0)) ? '0 : regs[ro_addr];

    // R6: register 0 stays zero even after a write aimed at it
    assert_r0_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == AW'(0)) |=> (regs[0] == '0));

    assert_r0_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_addr == AW'(0)) |-> (ro_data == '0));

endmodule

// File: rtl/scpu_dmem.sv
module scpu_dmem
    import scpu_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int W     = XLEN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(WORDS)-1:0] addr,
    input  logic                     we,
    input  logic [W-1:0]             wd,
    output logic [W-1:0]             rd
);

    localparam int AW         = $clog2(WORDS);
    localparam int INIT_WORDS = 4;
    localparam int INIT_BASE  = 3;

    logic [W-1:0] mem [WORDS];

    function automatic logic [W-1:0] init_word(input int unsigned i);
        return (i < INIT_WORDS) ? W'(i + INIT_BASE) : '0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= init_word(i);
        end else if (we) begin
            mem[addr] <= wd;
        end
    end

    assign rd = mem[addr];

    // R9: a stored word is what the same word reads back afterwards
    assert_store_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wd)));

    logic [AW-1:0] unused_aw;
    assign unused_aw = '0;

endmodule

// File: rtl/scpu_core.sv
module scpu_core
    import scpu_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] pc_o,
    input  logic [RA_W-1:0] obs_sel,
    output logic [XLEN-1:0] obs_data
);

    localparam int IAW      = $clog2(IMEM_WORDS);
    localparam int DAW      = $clog2(DMEM_WORDS);
    localparam int PC_HI    = 4;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, pc_d, pc_plus4;
    logic [XLEN-1:0] instr;
    instr_class_e    cls;
    ctrl_t           ctrl;

    logic [RA_W-1:0]  rs, rt, rd, dst;
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] jidx;
    logic [XLEN-1:0]  rs_val, rt_val, imm_ext, br_off;
    logic [XLEN-1:0]  alu_b, alu_y, mem_rd, wb_data;
    logic             alu_zero;
    logic [4:0]       unused_shamt;
    instr_class_e     unused_cls;

    // ---------------- program counter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_plus4 = pc_q + STEP;
    assign br_off   = {imm_ext[XLEN-3:0], 2'b00};

    always_comb begin
        if (ctrl.jump_reg)
            pc_d = rs_val;
        else if (ctrl.jump)
            pc_d = {pc_plus4[XLEN-1 -: PC_HI], jidx, 2'b00};
        else if (ctrl.branch_eq && alu_zero)
            pc_d = pc_plus4 + br_off;
        else
            pc_d = pc_plus4;
    end

    assign pc_o = pc_q;

    // ---------------- fetch and field split ----------------
    assign instr = prog_word(32'(pc_q[IAW+1:2]));

    assign rs           = instr[25:21];
    assign rt           = instr[20:16];
    assign rd           = instr[15:11];
    assign unused_shamt = instr[10:6];
    assign imm          = instr[IMM_W-1:0];
    assign jidx         = instr[IDX_W-1:0];
    assign unused_cls   = cls;

    scpu_decoder u_dec (
        .opcode (instr[XLEN-1 -: OP_W]),
        .funct  (instr[FN_W-1:0]),
        .cls    (cls),
        .ctrl   (ctrl)
    );

    assign imm_ext = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm}
                                   : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign dst     = ctrl.dst_is_rd ? rd : rt;

    // ---------------- register file ----------------
    scpu_regfile #(.NREG(REG_COUNT), .W(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (rs),
        .ra_data (rs_val),
        .rb_addr (rt),
        .rb_data (rt_val),
        .ro_addr (obs_sel),
        .ro_data (obs_data),
        .we      (ctrl.reg_write),
        .wa      (dst),
        .wd      (wb_data)
    );

    // ---------------- execute ----------------
    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    scpu_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // ---------------- data memory (partial decode) ----------------
    scpu_dmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (alu_y[DAW+1:2]),
        .we    (ctrl.mem_write),
        .wd    (rt_val),
        .rd    (mem_rd)
    );

    assign wb_data = ctrl.mem_to_reg ? mem_rd : alu_y;

    // ---------------- assertions ----------------
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.jump && !ctrl.jump_reg && !ctrl.branch_eq) |=> (pc_q == $past(pc_q) + STEP));

    assert_beq_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.branch_eq && rs_val == rt_val)
        |=> (pc_q == $past(pc_q) + STEP + {$past(imm[IMM_W-1]) ? {(XLEN-IMM_W-2){1'b1}} : {(XLEN-IMM_W-2){1'b0}}, $past(imm), 2'b00}));

    assert_beq_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.branch_eq && rs_val != rt_val) |=> (pc_q == $past(pc_q) + STEP));

    assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.jump |=> (pc_q[XLEN-PC_HI-1:0] == {$past(jidx), 2'b00}));

    assert_jr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.jump_reg |=> (pc_q == $past(rs_val)));

    assert_slt_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));

    assert_lui_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.alu_op == ALU_LUI) |-> (alu_y[IMM_W-1:0] == '0 && alu_y[XLEN-1:IMM_W] == imm));

endmodule

// File: tb/scpu_core_tb_top.sv
`timescale 1ns/1ps
module scpu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_o;
    logic [4:0]  obs_sel = '0;
    logic [31:0] obs_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    scpu_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_o     (pc_o),
        .obs_sel  (obs_sel),
        .obs_data (obs_data)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual=%0d cycles expected<=50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Expected PC after k edges of one pass (R2..R5, R11)
    function automatic logic [31:0] exp_pc(input int k);
        case (k)
            0: return 32'h00;   1: return 32'h04;   2: return 32'h08;
            3: return 32'h0C;   4: return 32'h10;   5: return 32'h14;
            6: return 32'h18;   7: return 32'h1C;   8: return 32'h20;
            9: return 32'h28;   10: return 32'h2C;  11: return 32'h24;
            12: return 32'h28;  13: return 32'h2C;  14: return 32'h24;
            15: return 32'h28;  16: return 32'h2C;  17: return 32'h30;
            18: return 32'h34;  19: return 32'h38;  20: return 32'h3C;
            21: return 32'h40;  default: return 32'h00;
        endcase
    endfunction

    function automatic string pc_req(input int k);
        if (k == 9) return "R4";
        if (k == 11 || k == 14 || k == 17) return "R3";
        if (k == 22) return "R5";
        return "R2";
    endfunction

    // Register contents at the end of a pass (R11)
    function automatic logic [31:0] exp_final(input int r);
        case (r)
            1: return 32'd3;  2: return 32'd4;  3: return 32'd7;
            4: return 32'd7;  5: return 32'd1;  6: return 32'd0;
            7: return 32'd1;  8: return 32'd2;  9: return 32'h2000_0014;
            10: return 32'd2;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd_reg(input int r, output logic [31:0] v);
        obs_sel = 5'(r);
        #0.05;
        v = obs_data;
    endtask

    task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(r, v);
        chk(req, $sformatf("r%0d", r), v, exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reads all 32 registers in a shuffled order (odd stride -> permutation)
    task automatic sweep(input bool_after_reset);
        int start;
        int stride;
        start  = int'($urandom_range(0, 31));
        stride = 2 * int'($urandom_range(0, 15)) + 1;
        for (int i = 0; i < 32; i++) begin
            int r;
            r = (start + i * stride) % 32;
            if (bool_after_reset)  chk_reg("R1", r, 32'd0);
            else if (r == 0)       chk_reg("R6", r, 32'd0);
            else if (r == 10)      chk_reg("R9", r, exp_final(r));
            else                   chk_reg("R11", r, exp_final(r));
        end
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        repeat (n) @(negedge clk);
        chk("R1", "pc during reset", pc_o, 32'h0);
        rst_n = 1'b1;
        chk("R1", "pc after reset", pc_o, 32'h0);
        sweep(1);
    endtask

    task automatic run_pass();
        for (int k = 1; k <= 22; k++) begin
            step();
            chk(pc_req(k), $sformatf("pc after %0d", k), pc_o, exp_pc(k));
            case (k)
                4: begin
                    chk_reg("R10", 1, 32'd3);
                    chk_reg("R10", 2, 32'd4);
                    chk_reg("R10", 3, 32'd5);
                end
                8: begin
                    chk_reg("R7", 3, 32'd7);
                    chk_reg("R7", 4, 32'd7);
                    chk_reg("R7", 5, 32'd1);
                    chk_reg("R7", 6, 32'd0);
                    chk_reg("R6", 8, 32'd0);
                end
                10: chk_reg("R7", 7, 32'd0);
                12: chk_reg("R8", 8, 32'd1);
                13: chk_reg("R7", 7, 32'd1);
                18: chk_reg("R8", 9, 32'h2000_0000);
                19: chk_reg("R8", 9, 32'h2000_0014);
                default: ;
            endcase
        end
        chk("R11", "pc at pass end", pc_o, 32'h0);
        sweep(0);
    endtask

    initial begin
        int passes;
        int stop_at;
        void'($urandom(32'h5EED_0C0E));
        do_reset(int'($urandom_range(2, 5)));
        run_pass();
        passes = int'($urandom_range(1, 3));
        repeat (passes) run_pass();
        stop_at = int'($urandom_range(1, 21));
        repeat (stop_at) step();
        do_reset(int'($urandom_range(1, 4)));
        run_pass();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule